// File: doc/BRIEF.md
# MDIO Management Controller with Change-Detect Polling

This block is the management master for two PHY management lines that share one clock pin. Software reaches it through a small register port. Three mechanisms drive the pins. In direct-drive mode, three one-bit registers place the clock, the data value and the output enable straight onto the pins. In transaction mode, software writes a 32-bit frame word and the block sends a preamble and then the frame. On a read, it releases the line for the turnaround and the data bits and captures the PHY's answer. In both cases it then marks the frame word as complete.

In transaction mode the block can also poll. It reads one chosen PHY register over and over, keeps the most recent value, and gathers every bit that has changed since the last time software read the status word. Any changed bit that is not masked raises the interrupt. A software transaction waiting in the frame register goes ahead of the next poll.

Register addresses on `reg_addr`: 0 configuration, 1 frame word, 2 status, 3 interrupt mask, 4 direct clock, 5 direct data, 6 direct output enable.

Top module: `mdio_mgmt`

## Requirements
- R1: A transaction sends 32 preamble ones and then frame-word bits 31 down to 0, most significant first. The frame word fields are: 31:30 start (01), 29:28 opcode (10 read, 01 write), 27:23 PHY address, 22:18 register address, 17:16 turnaround, 15:0 data. A write sends its turnaround bits as stored.
- R2: A frame-word write stores the word with bit 16 cleared and starts a transaction. When the transaction ends, bit 16 reads 1 and bits 15:0 hold the captured data for a read, or the written data for a write.
- R3: During a read, the output enable stays low for both turnaround bit times and all 16 data bits. Data is sampled on the rising edge of MDC.
- R4: Configuration bit 0 selects the active line (0 or 1). The enable of the other line is always low, and input data is taken only from the selected line.
- R5: With configuration bit 2 set, MDC, the data out and the selected line's enable follow the direct clock, data and enable registers. Reading the direct data address returns the selected line's input.
- R6: With configuration bit 1 set and bit 2 clear, the block issues back-to-back reads of PHY address cfg[14:10], register cfg[7:3]. With bit 2 set, no transactions appear on the pins.
- R7: The status word holds the last polled value in bits 31:16 (0 after reset). Bits 15:0 hold every bit that differed between consecutive polled values, sticky until a status read with `reg_rd` high clears them.
- R8: The interrupt mask uses 1 to mean masked and resets to 0xFFFF. `irq` is high while any changed bit is unmasked.
- R9: A pending software frame is sent before the next poll, and its result does not alter the status word.
- R10: A frame-word write is ignored while a software transaction is pending or running.
- R11: During a transaction, MDC has a period of 2*CLK_DIV clocks. Outside direct-drive mode, MDC is low when idle.
- R12: After reset, configuration, frame word, status and direct registers read 0, the mask reads 0xFFFF, and `irq`, MDC and both enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears changed bits on status) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| mdc | output | 1 | Management clock to both PHYs |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 2 | Output enable per line |
| mdio_i | input | 2 | Management data in per line |
| irq | output | 1 | Unmasked change interrupt |

## Verification
The checker watches the following on every cycle:
- the unselected line stays quiet;
- direct-drive mode owns MDC;
- the line is released through the read turnaround and data bits;
- MDC is low when idle;
- changed bits stay sticky;
- a status read drops `irq`;
- the frame's done bit is set when a software transaction retires.

Only the bench's scenarios can show the other behaviours. These are the bit-exact serial frames and preamble length, the captured read data per line, the values seen by polling and the accumulated change bits, masking, the priority of software frames over polls, frame writes that are ignored, and polling stopping in direct-drive mode.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;
  localparam int ADDR_W     = 3;
  localparam int REG_W      = 32;
  localparam int N_LINES    = 2;
  localparam int DATA_W     = 16;
  localparam int FRAME_W    = 32;
  localparam int PRE_LEN    = 32;
  localparam int CFG_W      = 15;
  localparam int TOTAL_BITS = PRE_LEN + FRAME_W;
  localparam int IDX_W      = $clog2(TOTAL_BITS);
  localparam int FPOS_W     = $clog2(FRAME_W);
  // serial position of the first turnaround bit and first data bit
  localparam int TA_FIRST   = PRE_LEN + FRAME_W - DATA_W - 2;
  localparam int DATA_FIRST = TA_FIRST + 2;
  localparam int DONE_BIT   = DATA_W;      // low turnaround bit flags completion
  localparam int OP_LO      = 28;
  localparam logic [1:0] OP_READ  = 2'b10;
  localparam logic [1:0] START_PAT = 2'b01;

  typedef enum logic [ADDR_W-1:0] {
    RA_CFG    = 3'd0,
    RA_FRAME  = 3'd1,
    RA_STATUS = 3'd2,
    RA_IMASK  = 3'd3,
    RA_BBCLK  = 3'd4,
    RA_BBDATA = 3'd5,
    RA_BBOE   = 3'd6
  } reg_addr_e;
endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
  parameter int DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  output logic tick_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (!en_i || cnt_q == LAST) cnt_d = '0;
    else                        cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick_o = en_i && (cnt_q == LAST);
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_mgmt_pkg::*;
#(
  parameter int CLK_DIV = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic               din_i,
  output logic               busy_o,
  output logic               rd_o,
  output logic [IDX_W-1:0]   idx_o,
  output logic               mdc_o,
  output logic               dout_o,
  output logic               oe_o,
  output logic               done_o,
  output logic [FRAME_W-1:0] result_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(TOTAL_BITS - 1);
  localparam logic [IDX_W-1:0] PRE_IDX  = IDX_W'(PRE_LEN);
  localparam logic [IDX_W-1:0] TA_IDX   = IDX_W'(TA_FIRST);
  localparam logic [IDX_W-1:0] DAT_IDX  = IDX_W'(DATA_FIRST);

  logic               tick;
  logic               busy_q, busy_d, mdc_q, mdc_d, rd_q, rd_d, done_q, done_d;
  logic [IDX_W-1:0]   idx_q, idx_d;
  logic [FRAME_W-1:0] frm_q, frm_d;
  logic [DATA_W-1:0]  rx_q, rx_d;
  logic [FPOS_W-1:0]  fpos;

  mdio_clk_div #(.DIV(CLK_DIV)) u_div (
    .clk(clk), .rst_n(rst_n), .en_i(busy_q), .tick_o(tick)
  );

  always_comb begin
    busy_d = busy_q; mdc_d = mdc_q; rd_d = rd_q; idx_d = idx_q;
    frm_d  = frm_q;  rx_d  = rx_q;  done_d = 1'b0;
    if (!busy_q) begin
      if (start_i) begin
        busy_d = 1'b1; idx_d = '0; mdc_d = 1'b0; frm_d = frame_i; rx_d = '0;
        rd_d   = (frame_i[OP_LO+1:OP_LO] == OP_READ);
      end
    end else if (tick) begin
      if (!mdc_q) begin
        mdc_d = 1'b1;
        if (rd_q && idx_q >= DAT_IDX) rx_d = {rx_q[DATA_W-2:0], din_i};
      end else begin
        mdc_d = 1'b0;
        if (idx_q == LAST_IDX) begin
          busy_d = 1'b0;
          done_d = 1'b1;
        end else begin
          idx_d = idx_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0; mdc_q <= 1'b0; rd_q <= 1'b0; done_q <= 1'b0;
      idx_q  <= '0;   frm_q <= '0;   rx_q <= '0;
    end else begin
      busy_q <= busy_d; mdc_q <= mdc_d; rd_q <= rd_d; done_q <= done_d;
      idx_q  <= idx_d;  frm_q <= frm_d; rx_q <= rx_d;
    end
  end

  // frame bit sent at serial position idx (valid once past the preamble)
  assign fpos     = FPOS_W'(LAST_IDX - idx_q);
  assign dout_o   = busy_q && ((idx_q < PRE_IDX) || frm_q[fpos]);
  assign oe_o     = busy_q && !(rd_q && idx_q >= TA_IDX);
  assign mdc_o    = mdc_q;
  assign busy_o   = busy_q;
  assign rd_o     = rd_q;
  assign idx_o    = idx_q;
  assign done_o   = done_q;
  assign result_o = {frm_q[FRAME_W-1:DONE_BIT+1], 1'b1, rd_q ? rx_q : frm_q[DATA_W-1:0]};
endmodule

// File: rtl/mdio_mgmt.sv
module mdio_mgmt
  import mdio_mgmt_pkg::*;
#(
  parameter int CLK_DIV = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [REG_W-1:0]   reg_wdata,
  output logic [REG_W-1:0]   reg_rdata,
  output logic               mdc,
  output logic               mdio_o,
  output logic [N_LINES-1:0] mdio_oe,
  input  logic [N_LINES-1:0] mdio_i,
  output logic               irq
);
  logic [CFG_W-1:0]   cfg_q, cfg_d;
  logic [FRAME_W-1:0] frame_q, frame_d, poll_frame, start_frame, eng_result;
  logic               pend_q, pend_d, poll_act_q, poll_act_d;
  logic [DATA_W-1:0]  imask_q, imask_d, basic_q, basic_d, chg_q, chg_d;
  logic               bbclk_q, bbclk_d, bbdat_q, bbdat_d, bboe_q, bboe_d;
  logic               line_sel, poll_en, bb_mode, mdio_din, oe_mux, start;
  logic               eng_busy, eng_rd, eng_mdc, eng_dout, eng_oe, eng_done;
  logic               rd_clr, poll_done;
  logic [IDX_W-1:0]   eng_idx;
  reg_addr_e          addr_e;

  assign addr_e     = reg_addr_e'(reg_addr);
  assign line_sel   = cfg_q[0];
  assign poll_en    = cfg_q[1];
  assign bb_mode    = cfg_q[2];
  assign poll_frame = {START_PAT, OP_READ, cfg_q[14:10], cfg_q[7:3], 2'b00, {DATA_W{1'b0}}};
  assign start      = !eng_busy && !eng_done && !bb_mode && (pend_q || poll_en);
  assign start_frame = pend_q ? frame_q : poll_frame;
  assign rd_clr     = reg_rd && (addr_e == RA_STATUS);
  assign poll_done  = eng_done && poll_act_q;
  assign mdio_din   = mdio_i[line_sel];

  mdio_frame_engine #(.CLK_DIV(CLK_DIV)) u_eng (
    .clk(clk), .rst_n(rst_n), .start_i(start), .frame_i(start_frame),
    .din_i(mdio_din), .busy_o(eng_busy), .rd_o(eng_rd), .idx_o(eng_idx),
    .mdc_o(eng_mdc), .dout_o(eng_dout), .oe_o(eng_oe), .done_o(eng_done),
    .result_o(eng_result)
  );

  always_comb begin
    cfg_d = cfg_q; frame_d = frame_q; pend_d = pend_q; poll_act_d = poll_act_q;
    imask_d = imask_q; basic_d = basic_q;
    bbclk_d = bbclk_q; bbdat_d = bbdat_q; bboe_d = bboe_q;
    if (reg_wr) begin
      case (addr_e)
        RA_CFG:    cfg_d = reg_wdata[CFG_W-1:0];
        RA_FRAME:  if (!pend_q) begin
                     frame_d = reg_wdata;
                     frame_d[DONE_BIT] = 1'b0;
                     pend_d = 1'b1;
                   end
        RA_IMASK:  imask_d = reg_wdata[DATA_W-1:0];
        RA_BBCLK:  bbclk_d = reg_wdata[0];
        RA_BBDATA: bbdat_d = reg_wdata[0];
        RA_BBOE:   bboe_d  = reg_wdata[0];
        default:   ;
      endcase
    end
    if (start) poll_act_d = !pend_q;
    chg_d = rd_clr ? '0 : chg_q;
    if (eng_done) begin
      if (poll_act_q) begin
        basic_d = eng_result[DATA_W-1:0];
        chg_d   = chg_d | (basic_q ^ eng_result[DATA_W-1:0]);
      end else begin
        frame_d = eng_result;
        pend_d  = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0; frame_q <= '0; pend_q <= 1'b0; poll_act_q <= 1'b0;
      imask_q <= '1; basic_q <= '0; chg_q <= '0;
      bbclk_q <= 1'b0; bbdat_q <= 1'b0; bboe_q <= 1'b0;
    end else begin
      cfg_q <= cfg_d; frame_q <= frame_d; pend_q <= pend_d; poll_act_q <= poll_act_d;
      imask_q <= imask_d; basic_q <= basic_d; chg_q <= chg_d;
      bbclk_q <= bbclk_d; bbdat_q <= bbdat_d; bboe_q <= bboe_d;
    end
  end

  assign mdc    = bb_mode ? bbclk_q : eng_mdc;
  assign mdio_o = bb_mode ? bbdat_q : eng_dout;
  assign oe_mux = bb_mode ? bboe_q  : eng_oe;

  for (genvar g = 0; g < N_LINES; g++) begin : g_line_oe
    assign mdio_oe[g] = oe_mux && (32'(line_sel) == g);
  end

  always_comb begin
    case (addr_e)
      RA_CFG:    reg_rdata = REG_W'(cfg_q);
      RA_FRAME:  reg_rdata = frame_q;
      RA_STATUS: reg_rdata = {basic_q, chg_q};
      RA_IMASK:  reg_rdata = REG_W'(imask_q);
      RA_BBCLK:  reg_rdata = REG_W'(bbclk_q);
      RA_BBDATA: reg_rdata = REG_W'(mdio_din);
      RA_BBOE:   reg_rdata = REG_W'(bboe_q);
      default:   reg_rdata = '0;
    endcase
  end

  assign irq = |(chg_q & ~imask_q);
endmodule

// File: rtl/mdio_mgmt_chk.sv
module mdio_mgmt_chk
  import mdio_mgmt_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               bb_mode,
  input logic               line_sel,
  input logic               bbclk,
  input logic               mdc,
  input logic [N_LINES-1:0] mdio_oe,
  input logic               eng_busy,
  input logic               eng_rd,
  input logic [IDX_W-1:0]   eng_idx,
  input logic               rd_clr,
  input logic               poll_done,
  input logic [DATA_W-1:0]  chg,
  input logic               irq,
  input logic               pend,
  input logic               done_flag
);
  a_r4_unselected_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (line_sel ? !mdio_oe[0] : !mdio_oe[1]));

  a_r5_direct_clock: assert property (@(posedge clk) disable iff (!rst_n)
    bb_mode |-> (mdc == bbclk));

  a_r3_release_line: assert property (@(posedge clk) disable iff (!rst_n)
    (!bb_mode && eng_busy && eng_rd && eng_idx >= IDX_W'(TA_FIRST)) |-> (mdio_oe == '0));

  a_r11_idle_clock_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!bb_mode && !eng_busy) |-> !mdc);

  a_r7_changes_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_clr && !poll_done) |=> (($past(chg) & ~chg) == '0));

  a_r8_read_drops_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && !poll_done) |=> !irq);

  a_r2_retire_marks_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pend) |-> done_flag);
endmodule

bind mdio_mgmt mdio_mgmt_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bb_mode(bb_mode), .line_sel(line_sel), .bbclk(bbclk_q),
  .mdc(mdc), .mdio_oe(mdio_oe), .eng_busy(eng_busy), .eng_rd(eng_rd), .eng_idx(eng_idx),
  .rd_clr(rd_clr), .poll_done(poll_done), .chg(chg_q), .irq(irq), .pend(pend_q),
  .done_flag(frame_q[DONE_BIT])
);

// File: tb/mdio_mgmt_bench.sv
module mdio_mgmt_bench;
  localparam int DIV = 2;
  localparam int WD  = 150000;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        mdc, mdio_o, irq;
  logic [1:0]  mdio_oe;
  logic [1:0]  in_q = 2'b00;

  mdio_mgmt #(.CLK_DIV(DIV)) u_mdio_mgmt (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .mdio_i(in_q), .irq(irq)
  );

  always #10 clk = ~clk;   // 50 MHz

  int n_chk = 0, n_fail = 0, cyc = 0;
  // bench-side model of software-visible setup
  logic m_bb = 0, m_sel = 0, m_bbclk = 0, m_bbdat = 0, m_bboe = 0;
  logic [15:0] poll_val = 16'h00F0;
  localparam logic [4:0] POLL_REG = 5'd9;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == WD) begin
      n_fail++;
      $display("FAIL watchdog (all) actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  // every-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R4 unselected enable", {31'b0, mdio_oe[~m_sel]}, 32'd0);
      if (m_bb) begin
        chk("R5 direct clock", {31'b0, mdc}, {31'b0, m_bbclk});
        chk("R5 direct data", {31'b0, mdio_o}, {31'b0, m_bbdat});
        chk("R5 direct enable", {31'b0, mdio_oe[m_sel]}, {31'b0, m_bboe});
      end
    end
  end

  // behavioural PHY: decodes serial frames and answers reads
  logic [27:0] txq[$];   // {ok, rd, phy, reg, data}
  int ph_st = 0, ph_ones = 0, ph_n = 0, last_rise = 0;
  logic ph_ok = 1'b1, ph_rd = 1'b0;
  logic [12:0] ph_hdr = '0;
  logic [17:0] ph_w = '0;
  logic [15:0] ph_rdv = '0, ph_rx = '0;
  wire oe_s = mdio_oe[m_sel];

  always @(posedge mdc) begin
    if (m_bb) begin
      ph_st = 0; ph_ones = 0;
    end else begin
      if ((ph_st != 0 || ph_ones != 0) && (cyc - last_rise != 2 * DIV)) ph_ok = 1'b0; // R11
      last_rise = cyc;
      case (ph_st)
        0: if (oe_s && mdio_o) begin
             if (ph_ones == 0) ph_ok = 1'b1;
             ph_ones++;
           end else if (oe_s && !mdio_o && ph_ones >= 32) begin
             if (ph_ones != 32) ph_ok = 1'b0;   // R1 preamble length
             ph_st = 1; ph_n = 0; ph_hdr = '0;
           end else ph_ones = 0;
        1: begin
             if (!oe_s) ph_ok = 1'b0;
             ph_hdr = {ph_hdr[11:0], mdio_o}; ph_n++;
             if (ph_n == 13) begin
               if (!ph_hdr[12]) ph_ok = 1'b0;
               ph_rd = (ph_hdr[11:10] == 2'b10);
               ph_rdv = (ph_hdr[4:0] == POLL_REG) ? poll_val
                        : {3'b101, ph_hdr[9:5], ph_hdr[4:0], 3'b000};
               ph_st = ph_rd ? 2 : 3; ph_n = 0; ph_w = '0;
             end
           end
        2: begin
             if (oe_s) ph_ok = 1'b0;          // R3 turnaround released
             ph_n++;
             if (ph_n == 2) begin ph_st = 4; ph_n = 0; end
           end
        3: begin
             if (!oe_s) ph_ok = 1'b0;
             ph_w = {ph_w[16:0], mdio_o}; ph_n++;
             if (ph_n == 18) begin
               if (ph_w[17:16] != 2'b10) ph_ok = 1'b0;
               txq.push_back({ph_ok, 1'b0, ph_hdr[9:5], ph_hdr[4:0], ph_w[15:0]});
               ph_st = 0; ph_ones = 0;
             end
           end
        default: begin
             if (oe_s) ph_ok = 1'b0;          // R3 data bits released
             ph_n++;
             if (ph_n == 16) begin
               txq.push_back({ph_ok, 1'b1, ph_hdr[9:5], ph_hdr[4:0], ph_rdv});
               ph_st = 0; ph_ones = 0;
             end
           end
      endcase
    end
  end

  always @(negedge mdc) begin
    if (!m_bb && ph_st == 4 && ph_n < 16) in_q[m_sel] = ph_rdv[15 - ph_n];
  end

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    #1;
    reg_wr = 1'b0;
    case (a)
      3'd0: begin m_sel = d[0]; m_bb = d[2]; end
      3'd4: m_bbclk = d[0];
      3'd5: m_bbdat = d[0];
      3'd6: m_bboe = d[0];
      default: ;
    endcase
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] v);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    #1;
    v = reg_rdata;
    @(posedge clk);
    #1;
    reg_rd = 1'b0;
  endtask

  task automatic wait_cyc(int n);
    for (int i = 0; i < n; i++) @(posedge clk);
  endtask

  task automatic wait_log(int n);
    for (int k = 0; k < 6000 && txq.size() < n; k++) @(posedge clk);
  endtask

  task automatic wait_sw(output logic [31:0] v);
    v = '0;
    for (int k = 0; k < 3000; k++) begin
      rd(3'd1, v);
      if (v[16]) break;
    end
  endtask

  function automatic logic [31:0] mkframe(logic [1:0] op, logic [4:0] phy, logic [4:0] ra,
                                          logic [1:0] ta, logic [15:0] d);
    return {2'b01, op, phy, ra, ta, d};
  endfunction

  function automatic logic [31:0] mkcfg(logic sel, logic poll, logic bb, logic [4:0] preg,
                                        logic [4:0] pphy);
    return {17'b0, pphy, 2'b00, preg, bb, poll, sel};
  endfunction

  initial begin
    logic [31:0] v, f;
    logic [27:0] e;
    int sz;
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(2);

    // R12 reset state
    rd(3'd0, v); chk("R12 cfg reset", v, 32'd0);
    rd(3'd3, v); chk("R12 mask reset", v, 32'h0000FFFF);
    rd(3'd1, v); chk("R12 frame reset", v, 32'd0);
    rd(3'd2, v); chk("R12 status reset", v, 32'd0);
    chk("R12 pins reset", {28'b0, irq, mdc, mdio_oe}, 32'd0);

    // R5 direct drive and input selection
    in_q = 2'b01;
    wr(3'd0, mkcfg(0, 0, 1, 0, 0));
    wr(3'd4, 1); wr(3'd5, 1); wr(3'd6, 1); wait_cyc(3);
    rd(3'd5, v); chk("R5 direct input line0", v, 32'd1);
    wr(3'd0, mkcfg(1, 0, 1, 0, 0)); wait_cyc(2);
    rd(3'd5, v); chk("R5 direct input line1 R4", v, 32'd0);
    wr(3'd4, 0); wr(3'd6, 0); wr(3'd5, 0); wait_cyc(3);
    wr(3'd0, mkcfg(0, 0, 0, 0, 0)); in_q = 2'b00; wait_cyc(4);
    chk("R11 idle clock low", {31'b0, mdc}, 32'd0);

    // R1 R2 write transaction on line 0
    txq.delete();
    f = mkframe(2'b01, 5'd5, 5'd3, 2'b10, 16'hBEEF);
    wr(3'd1, f);
    rd(3'd1, v); chk("R2 done bit clear while pending", {31'b0, v[16]}, 32'd0);
    wait_sw(v);
    chk("R2 write completes", v, f | 32'h00010000);
    wait_log(1);
    e = (txq.size() > 0) ? txq.pop_front() : '0;
    chk("R1 R11 write frame on wire", {4'b0, e}, {4'b0, 1'b1, 1'b0, 5'd5, 5'd3, 16'hBEEF});

    // R3 R4 read transaction on line 1
    wr(3'd0, mkcfg(1, 0, 0, 0, 0));
    f = mkframe(2'b10, 5'd2, 5'd7, 2'b00, 16'h0000);
    wr(3'd1, f);
    wait_sw(v);
    chk("R2 R4 read data line1", v, {f[31:17], 1'b1, 3'b101, 5'd2, 5'd7, 3'b000});
    e = (txq.size() > 0) ? txq.pop_front() : '0;
    chk("R3 read released", {4'b0, e}, {4'b0, 1'b1, 1'b1, 5'd2, 5'd7, 3'b101, 5'd2, 5'd7, 3'b000});

    // R10 second frame write ignored while pending
    wr(3'd0, mkcfg(0, 0, 0, 0, 0));
    txq.delete();
    f = mkframe(2'b01, 5'd1, 5'd2, 2'b10, 16'h1234);
    wr(3'd1, f);
    wr(3'd1, mkframe(2'b01, 5'd3, 5'd4, 2'b10, 16'h5678));
    wait_sw(v);
    chk("R10 first frame kept", v, f | 32'h00010000);
    wait_cyc(400);
    chk("R10 one transaction", txq.size(), 1);

    // R6 R7 polling, all bits masked
    txq.delete();
    wr(3'd0, mkcfg(0, 1, 0, POLL_REG, 5'd4));
    wait_log(2); wait_cyc(10);
    e = (txq.size() > 1) ? txq[1] : '0;
    chk("R6 poll frame", {4'b0, e}, {4'b0, 1'b1, 1'b1, 5'd4, POLL_REG, 16'h00F0});
    chk("R8 masked no irq", {31'b0, irq}, 32'd0);
    rd(3'd2, v); chk("R7 first poll status", v, 32'h00F000F0);
    rd(3'd2, v); chk("R7 cleared on read", v, 32'h00F00000);

    // R8 unmasked change raises irq
    wr(3'd3, 32'h0000FFFE);
    poll_val = 16'h00F3;
    sz = txq.size(); wait_log(sz + 2); wait_cyc(10);
    chk("R8 irq on unmasked change", {31'b0, irq}, 32'd1);
    rd(3'd2, v); chk("R7 changed bits", v, 32'h00F30003);
    @(negedge clk);
    chk("R8 irq drops after read", {31'b0, irq}, 32'd0);
    poll_val = 16'h00B3;
    sz = txq.size(); wait_log(sz + 2); wait_cyc(10);
    chk("R8 masked change quiet", {31'b0, irq}, 32'd0);
    rd(3'd2, v); chk("R7 masked change recorded", v, 32'h00B30040);

    // R9 software read while polling
    f = mkframe(2'b10, 5'd2, 5'd7, 2'b00, 16'h0000);
    wr(3'd1, f);
    wait_sw(v);
    chk("R9 sw read during poll", v, {f[31:17], 1'b1, 3'b101, 5'd2, 5'd7, 3'b000});
    wait_cyc(300);
    rd(3'd2, v); chk("R9 status untouched", v, 32'h00B30000);
    sz = 0;
    foreach (txq[i]) if (txq[i][20:16] == 5'd7) sz++;
    chk("R9 sw frame on wire", sz, 1);

    // R6 direct-drive mode halts polling
    wr(3'd0, mkcfg(0, 1, 1, POLL_REG, 5'd4));
    wait_cyc(300);
    sz = txq.size();
    wait_cyc(600);
    chk("R6 no poll in direct mode", txq.size(), sz);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule